// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A general-purpose up-counting timer for a peripheral cluster, controlled through a small register port. Software picks a divide for the system clock and an optional extra divide-by-16 stage. It loads a compare value and enables the timer. On each divided tick the counter moves by one. When a tick finds the counter equal to the compare value, the timer latches a sticky compare event. The counter then either restarts from zero or keeps counting and wraps at its top value.

The interrupt line is the latched compare event, qualified by an enable bit in the control word. Software acknowledges the event by writing a one to its bit. Taking the enable bit from 1 to 0 with a control write also clears the compare value. Register reads are combinational from the address. Writes take effect at the clock edge where `wr_en` is high.

Top module: `refcmp_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low.
- R2: Register offsets are fixed: control at 0x00, compare at 0x04, capture at 0x08, counter at 0x0C and event at 0x11. Any other offset reads zero. The capture register holds whatever software last wrote to it. Event bit 0 (capture) is never set by the block.
- R3: The control word is laid out as follows. Bit 0 is the enable. Bits 2:1 are the tick source. Bit 3 is the restart mode. Bit 4 is the interrupt enable. Bits 15:8 are the divide byte H. Bits 7:5 are stored and read back but have no effect. With the enable set and source 1, the counter advances once every H+1 clocks. With source 2 it advances once every 16*(H+1) clocks. Source 0, source 3 or a cleared enable hold the counter.
- R4: A tick that finds the counter equal to the compare value sets event bit 1. In restart mode (control bit 3 = 1) the counter then returns to zero, so the event recurs every compare+1 ticks.
- R5: With restart mode off, the counter runs through 0xFFFF to 0x0000. A tick at the compare value still sets event bit 1.
- R6: Writing the event register clears each bit that is written as 1 and leaves the other bits as they were. A compare event in the same cycle as a clearing write wins, so the bit stays set.
- R7: `irq` is high exactly when control bit 4 and event bit 1 are both set.
- R8: A control write whose value has bit 0 = 0, made while bit 0 is set, clears the compare register. The control register takes the written value.
- R9: A write to the control or compare register clears the counter and the prescaler. A counter write loads the written value and restarts the prescaler. Either kind of write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Compare interrupt request |

## Verification
Two things can land on the same edge. One is the compare event, raised by the counter path. The other is a software write, either an event-clear write or a counter/control write. The bench creates both collisions by setting compare = 0 with a divide of one, so every tick is a compare match. It then clears event bit 1 while matches keep arriving, and expects the bit and `irq` to stay high. It also writes the counter while the timer is ticking, and expects the loaded value rather than an increment. Away from these collisions, the bench sweeps divide bytes, both tick sources and several compare values. It predicts the count and the event from the number of elapsed clocks.

// File: rtl/tmr_pkg.sv
// Package: register offsets and control-word bit positions for the
// prescaled reference-compare timer. The tick-source code values are
// part of the programming model, so they are fixed here.
package tmr_pkg;
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_CMP  = 'h04;
    localparam int OFF_CAP  = 'h08;
    localparam int OFF_CNT  = 'h0C;
    localparam int OFF_EVT  = 'h11;

    localparam int CB_EN      = 0;
    localparam int CB_SRC_LO  = 1;
    localparam int CB_RESTART = 3;
    localparam int CB_IRQ_EN  = 4;
    localparam int CB_DIV_LO  = 8;

    typedef enum logic [1:0] {
        SRC_OFF0 = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_OFF3 = 2'd3
    } tick_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Makes a one-cycle tick every (div_hi+1) clocks, or every
// 2**FINE_W*(div_hi+1) clocks when fine_en is set.
// Assumes: tick is combinational from the stage counters. clr and !run
// put both stages back to zero, so the first tick after a clear comes a
// full period later.
module tmr_prescaler #(
    parameter int PRE_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             fine_en,
    input  logic [PRE_W-1:0] div_hi,
    output logic             tick
);
    logic [PRE_W-1:0]  pre_q;
    logic [FINE_W-1:0] fine_q;
    logic              pre_wrap;

    // Purpose: flag the cycle where the coarse stage reaches its limit.
    always_comb pre_wrap = (pre_q == div_hi);

    // Purpose: tick only when every enabled stage is at its limit.
    always_comb tick = run && pre_wrap && (!fine_en || (fine_q == '1));

    // Purpose: advance the coarse stage, and the fine stage on each coarse wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            pre_q  <= '0;
            fine_q <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            if (fine_en)
                fine_q <= fine_q + 1'b1;
            else
                fine_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// The timer count with compare and restart. Priority: clr, then load,
// then tick. hit pulses on a tick that finds count equal to cmp_val,
// unless a clear or load in the same cycle overrides it.
// Assumes: tick already includes the enable and source qualification.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic match;

    // Purpose: detect equality between the count and the compare value.
    always_comb match = (count == cmp_val);

    // Purpose: report a compare event that this cycle's tick really takes.
    always_comb hit = tick && match && !clr && !load;

    // Purpose: update the count by priority: clear, load, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick) begin
            if (match && restart)
                count <= '0;
            else
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/refcmp_timer.sv
// Module: refcmp_timer (top)
// Register file, decode, the sticky event register and the interrupt,
// built around the prescaler and the counter.
// Assumes: ADDR_W is wide enough for offset 0x11. The control word
// (8 + PRE_W bits) fits in CNT_W.
module refcmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int FINE_W = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int CTRL_W = 8 + PRE_W;
    localparam int EVT_W  = 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cap_q;
    logic [CNT_W-1:0]  count_q;
    logic [EVT_W-1:0]  evt_q;
    logic [EVT_W-1:0]  evt_nxt;
    logic              wr_ctrl, wr_cmp, wr_cap, wr_cnt, wr_evt;
    logic              run, fine_en, tick, hit;
    tick_src_e         src;

    // Purpose: decode the write strobe per register.
    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));
        wr_cmp  = wr_en && (addr == ADDR_W'(OFF_CMP));
        wr_cap  = wr_en && (addr == ADDR_W'(OFF_CAP));
        wr_cnt  = wr_en && (addr == ADDR_W'(OFF_CNT));
        wr_evt  = wr_en && (addr == ADDR_W'(OFF_EVT));
    end

    // Purpose: derive the run state and the tick source from the control word.
    always_comb begin
        src     = tick_src_e'(ctrl_q[CB_SRC_LO +: 2]);
        run     = ctrl_q[CB_EN] && (src == SRC_DIV || src == SRC_DIV16);
        fine_en = (src == SRC_DIV16);
    end

    // Purpose: hold control, compare and capture; disabling clears compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            cap_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wr_data[CTRL_W-1:0];
                if (ctrl_q[CB_EN] && !wr_data[CB_EN])
                    cmp_q <= '0;
            end
            if (wr_cmp)
                cmp_q <= wr_data;
            if (wr_cap)
                cap_q <= wr_data;
        end
    end

    // Purpose: apply write-one-to-clear first, then let a compare hit set bit 1.
    always_comb begin
        evt_nxt = evt_q;
        if (wr_evt)
            evt_nxt = evt_nxt & ~wr_data[EVT_W-1:0];
        if (hit)
            evt_nxt[1] = 1'b1;
    end

    // Purpose: register the event bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else
            evt_q <= evt_nxt;
    end

    tmr_prescaler #(.PRE_W(PRE_W), .FINE_W(FINE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_ctrl || wr_cmp || wr_cnt),
        .run     (run),
        .fine_en (fine_en),
        .div_hi  (ctrl_q[CB_DIV_LO +: PRE_W]),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_ctrl || wr_cmp),
        .load     (wr_cnt),
        .load_val (wr_data),
        .tick     (tick),
        .restart  (ctrl_q[CB_RESTART]),
        .cmp_val  (cmp_q),
        .count    (count_q),
        .hit      (hit)
    );

    // Purpose: interrupt is the enabled, latched compare event.
    always_comb irq = ctrl_q[CB_IRQ_EN] && evt_q[1];

    // Purpose: combinational read multiplexer; unmapped offsets return zero.
    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(OFF_CTRL): rd_data = CNT_W'(ctrl_q);
            ADDR_W'(OFF_CMP):  rd_data = cmp_q;
            ADDR_W'(OFF_CAP):  rd_data = cap_q;
            ADDR_W'(OFF_CNT):  rd_data = count_q;
            ADDR_W'(OFF_EVT):  rd_data = CNT_W'(evt_q);
            default:           rd_data = '0;
        endcase
    end
endmodule

// File: rtl/refcmp_timer_chk.sv
// Module: refcmp_timer_chk
// Temporal checks on the timer, bound into refcmp_timer.
// Assumes: the same offsets and control bits as tmr_pkg.
module refcmp_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CTRL_W = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [1:0]        evt_q
);
    // R3: a disabled timer with no write keeps its count
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CB_EN] && !wr_en) |=> $stable(count_q));

    // R5: outside restart mode and without writes the count only steps by one
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ctrl_q[CB_RESTART]) |=>
        (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1)));

    // R9: a control write leaves the counter at zero
    p_ctrl_clears_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CTRL)) |=> (count_q == '0));

    // R8: disabling through a control write empties the compare register
    p_disable_clears_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CTRL) && ctrl_q[CB_EN] && !wr_data[CB_EN])
        |=> (cmp_q == '0));

    // R6: the compare event stays set until a one is written to its bit
    p_event_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[1] && !(wr_en && addr == ADDR_W'(OFF_EVT) && wr_data[1])) |=> evt_q[1]);

    // R7: the interrupt needs its enable bit
    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[CB_IRQ_EN]);

    // R2: the capture event bit is never raised
    p_capture_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_q[0]);
endmodule

bind refcmp_timer refcmp_timer_chk #(
    .CNT_W  (CNT_W),
    .CTRL_W (8 + PRE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .irq     (irq),
    .ctrl_q  (ctrl_q),
    .cmp_q   (cmp_q),
    .count_q (count_q),
    .evt_q   (evt_q)
);

// File: tb/refcmp_timer_tb.sv
`timescale 1ns/100ps
module refcmp_timer_tb;
    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_CMP  = 5'h04;
    localparam logic [4:0] A_CAP  = 5'h08;
    localparam logic [4:0] A_CNT  = 5'h0C;
    localparam logic [4:0] A_EVT  = 5'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    refcmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One write pulse, taken at the next rising edge; returns at the following falling edge.
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 16'h0);
        rd(A_CMP, v);  check("R1 cmp", v, 16'h0);
        rd(A_CAP, v);  check("R1 cap", v, 16'h0);
        rd(A_CNT, v);  check("R1 cnt", v, 16'h0);
        rd(A_EVT, v);  check("R1 evt", v, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);

        // R2: map, capture holds software value, unmapped offsets read zero
        wr(A_CAP, 16'hBEEF);
        rd(A_CAP, v);  check("R2 cap", v, 16'hBEEF);
        wr(A_CTRL, 16'hA5E0);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 16'hA5E0);
        rd(5'h10, v);  check("R2 unmapped 0x10", v, 16'h0);
        rd(5'h01, v);  check("R2 unmapped 0x01", v, 16'h0);
        rd(5'h14 & 5'h1F, v); check("R2 unmapped 0x14", v, 16'h0);
        wr(A_CTRL, 16'h0000);

        // R3/R4/R7: sweep divide byte, source, compare value in restart mode
        for (int h = 0; h < 4; h++) begin
            for (int s = 1; s <= 2; s++) begin
                for (int ci = 0; ci < 3; ci++) begin
                    int c, d, n1;
                    c = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
                    d = (h + 1) * ((s == 2) ? 16 : 1);
                    wr(A_CTRL, 16'h0000);
                    wr(A_EVT, 16'h0003);
                    wr(A_CMP, 16'(c));
                    wr(A_CTRL, {8'(h), 3'b000, 1'b1, 1'b1, 2'(s), 1'b1});
                    n1 = d * (c + 1) - 1;
                    idle(n1);
                    rd(A_CNT, v); check("R3 count before match", v, 16'((n1 / d) % (c + 1)));
                    rd(A_EVT, v); check("R4 event before match", v, 16'h0);
                    check("R7 irq before match", {15'h0, irq}, 16'h0);
                    idle(1);
                    rd(A_EVT, v); check("R4 event at match", v, 16'h2);
                    rd(A_CNT, v); check("R4 restart to zero", v, 16'h0);
                    check("R7 irq at match", {15'h0, irq}, 16'h1);
                end
            end
        end

        // R3: holding sources and a cleared enable
        wr(A_CTRL, 16'h0000);
        wr(A_CTRL, 16'h0001);
        wr(A_CNT, 16'h0005);
        idle(10);
        rd(A_CNT, v); check("R3 source 0 holds", v, 16'h0005);
        wr(A_CTRL, 16'h0007);
        wr(A_CNT, 16'h0009);
        idle(10);
        rd(A_CNT, v); check("R3 source 3 holds", v, 16'h0009);
        wr(A_CTRL, 16'h0000);
        wr(A_CTRL, 16'h0002);
        wr(A_CNT, 16'h0004);
        idle(10);
        rd(A_CNT, v); check("R3 disabled holds", v, 16'h0004);

        // R5: free-running wrap, match after the wrap
        wr(A_CTRL, 16'h0000);
        wr(A_EVT, 16'h0003);
        wr(A_CMP, 16'h0005);
        wr(A_CTRL, 16'h0003);
        wr(A_CNT, 16'hFFFE);
        idle(2);
        rd(A_CNT, v); check("R5 wrap", v, 16'h0000);
        rd(A_EVT, v); check("R5 no event on wrap", v, 16'h0);
        idle(6);
        rd(A_CNT, v); check("R5 continues past compare", v, 16'h0006);
        rd(A_EVT, v); check("R5 event after wrap", v, 16'h2);
        check("R7 irq gated off", {15'h0, irq}, 16'h0);

        // R9: load priority over tick, compare write clears count
        wr(A_CTRL, 16'h0000);
        wr(A_CMP, 16'd1000);
        wr(A_CTRL, 16'h000B);
        idle(20);
        rd(A_CNT, v); check("R9 running", v, 16'd20);
        wr(A_CNT, 16'd100);
        rd(A_CNT, v); check("R9 load beats tick", v, 16'd100);
        idle(3);
        rd(A_CNT, v); check("R9 count after load", v, 16'd103);
        wr(A_CMP, 16'd1000);
        rd(A_CNT, v); check("R9 compare write clears", v, 16'd0);
        idle(4);
        rd(A_CNT, v); check("R9 resumes", v, 16'd4);

        // R6: clearing write collides with a compare hit (compare 0, divide 1)
        wr(A_CTRL, 16'h0000);
        wr(A_EVT, 16'h0003);
        wr(A_CMP, 16'h0000);
        wr(A_CTRL, 16'h001B);
        idle(2);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v); check("R6 hit wins over clear", v, 16'h2);
        check("R6 irq stays high", {15'h0, irq}, 16'h1);

        // R8: disable clears compare, control takes written value
        wr(A_CMP, 16'h0007);
        wr(A_CTRL, 16'h001A);
        rd(A_CMP, v);  check("R8 compare cleared", v, 16'h0);
        rd(A_CTRL, v); check("R8 ctrl value", v, 16'h001A);
        check("R7 irq with event held", {15'h0, irq}, 16'h1);
        wr(A_EVT, 16'h0001);
        rd(A_EVT, v); check("R6 write of other bit leaves event", v, 16'h2);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v); check("R6 clear", v, 16'h0);
        check("R7 irq drops", {15'h0, irq}, 16'h0);
        wr(A_CMP, 16'h0007);
        wr(A_CTRL, 16'h0010);
        rd(A_CMP, v); check("R8 no clear when already disabled", v, 16'h0007);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule